// File: doc/BRIEF.md
# Semaphore-Gated Descriptor DMA Channel

This block is one DMA channel that runs a linked list of command descriptors held in memory. Software first places the word address of the first descriptor in the channel's next-command pointer. It then writes a count into the channel's semaphore. While the semaphore is nonzero and the channel is not clock-gated, the channel reads a three-word descriptor through a request/valid memory port and performs a placeholder transfer of the word count the descriptor names. On completion it may lower the semaphore, raise a sticky completion flag, and follow the descriptor's link to the next one.

The semaphore is additive. Each write adds to the pending count, and a command that asks for it removes one when it finishes. At any moment the count therefore tells software how many issued commands are still outstanding. When the count reaches zero, the channel stops and keeps the link it last followed. It resumes from that link on the next nonzero write. A level clock-gate input freezes the channel. A channel-reset pulse abandons whatever is in flight and returns the channel to idle.

Top module: `sdma_chan`

## Requirements
- R1: After `rst_n` is released, `sem_count` is 0, and `busy`, `mem_req`, `cmpl_flag`, `irq` and `xfer_beat` are all 0.
- R2: When a nonzero semaphore write arrives while the channel is idle and `gate` is low, the channel fetches the descriptor at `nxt_addr`. It reads three words in this order: byte offset 0 is the link word, offset 4 is the command word, offset 8 is the buffer address. `mem_req` and `mem_addr` are held until `mem_rvalid`.
- R3: Command word bits 31:16 give the transfer count N. After the fetch, the channel pulses `xfer_beat` once per cycle, N times in total, with `xfer_addr` equal to buffer, buffer+4, and so on. When N = 0 there is no beat.
- R4: When a command completes with command bit 6 set, `sem_count` falls by exactly one. When bit 6 is clear, `sem_count` is unchanged.
- R5: When a completed command has bit 2 set, `nxt_addr` takes that descriptor's link word. If the semaphore is then still nonzero, the channel fetches from the new address without further software action.
- R6: When the count reaches zero at the end of a command, the channel goes idle and issues no further fetch. A followed link stays in `nxt_addr`, and the next nonzero semaphore write starts there.
- R7: A semaphore write adds `sem_wval` to the current count and saturates at 255. A write of zero changes nothing and starts nothing.
- R8: While `gate` is high, no command starts and no `xfer_beat` occurs, and the channel holds its place. Lowering `gate` resumes from where the channel stopped.
- R9: Completion of a command with bit 3 set makes `cmpl_flag` 1, and it stays 1 until a `cmpl_clr` pulse. `irq` is `cmpl_flag` AND `irq_en`. Completion of a command with bit 3 clear does not set the flag.
- R10: A `chan_rst` pulse aborts the current command. One cycle later `busy` is 0 and `sem_count` is 0, and no further beats occur. `nxt_addr` keeps its value.
- R11: A write of `sw_nxt_word` takes effect only while the channel is idle. While busy it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_rst | input | 1 | Channel abort and clear pulse |
| gate | input | 1 | Clock-gate control; high freezes the channel |
| sw_nxt_we | input | 1 | Write strobe for the next-command pointer |
| sw_nxt_word | input | AW-2 | Word address of the next descriptor |
| sem_we | input | 1 | Semaphore write strobe |
| sem_wval | input | SEM_W | Value added to the semaphore |
| irq_en | input | 1 | Interrupt enable |
| cmpl_clr | input | 1 | Clears the completion flag |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Byte address of the read |
| mem_rvalid | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 32 | Read data |
| xfer_beat | output | 1 | One transfer word this cycle |
| xfer_addr | output | AW | Buffer address of this word |
| busy | output | 1 | Channel not idle |
| nxt_addr | output | AW | Current next-command byte address |
| sem_count | output | SEM_W | Outstanding command count |
| cmpl_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with its defaults: 32-bit addresses, an 8-bit semaphore with saturation, and a 16-bit count field. The 8-bit semaphore puts the 255 ceiling within reach of two writes. The 16-bit count field lets long transfers be cut by gating and by channel reset partway through. The bench's memory model answers with latencies of zero to three cycles. This tests that address and request stay stable over an unanswered request, across chains of one to three descriptors, including a zero-length command.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_DONE} sdma_state_e;

   // command word layout, relied on by descriptor writers
   localparam int CHAIN_BIT = 2;
   localparam int IRQ_BIT   = 3;
   localparam int DEC_BIT   = 6;
   localparam int CNT_LSB   = 16;
   localparam int DATA_W    = 32;
   localparam int DESC_WORDS = 3;
endpackage

// File: rtl/sdma_sem.sv
module sdma_sem #(
   parameter int SEM_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add_we,
   input  logic [SEM_W-1:0] add_val,
   input  logic             dec,
   output logic [SEM_W-1:0] count_q,
   output logic [SEM_W-1:0] count_d
);
   localparam logic [SEM_W-1:0] SEM_MAX = '1;

   logic [SEM_W:0]   sum;
   logic [SEM_W-1:0] capped;

   assign sum = {1'b0, count_q} + {1'b0, (add_we ? add_val : '0)};

   generate
      if (SATURATE) begin : g_sat
         assign capped = sum[SEM_W] ? SEM_MAX : sum[SEM_W-1:0];
      end else begin : g_wrap
         assign capped = sum[SEM_W-1:0];
      end
   endgenerate

   always_comb begin
      if (clr)                       count_d = '0;
      else if (dec && capped != '0)  count_d = capped - 1'b1;
      else                           count_d = capped;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_d;
   end
endmodule

// File: rtl/sdma_flag.sv
module sdma_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic en,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   assign irq = flag & en;
endmodule

// File: rtl/sdma_fsm.sv
module sdma_fsm
   import sdma_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_rst,
   input  logic              run_en,
   input  logic              arm_set,
   input  logic              sem_nz,
   input  logic              sem_nz_next,
   input  logic              sw_nxt_we,
   input  logic [AW-3:0]     sw_nxt_word,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              xfer_beat,
   output logic [AW-1:0]     xfer_addr,
   output logic              busy,
   output logic [AW-1:0]     nxt_addr,
   output logic              done_dec,
   output logic              done_irq
);
   localparam int IDX_W = $clog2(DESC_WORDS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

   sdma_state_e      state;
   logic [IDX_W-1:0] idx;
   logic             armed;
   logic [AW-3:0]    nxt_word;
   logic [AW-3:0]    lnk_word;
   logic             c_chain, c_irq, c_dec;
   logic [CNT_W-1:0] c_cnt;
   logic [AW-1:0]    buf_base;
   logic [CNT_W-1:0] remain;
   logic [CNT_W-1:0] beat_ix;
   logic             done_fire;

   assign nxt_addr  = {nxt_word, 2'b00};
   assign mem_req   = (state == ST_FETCH);
   assign mem_addr  = nxt_addr + (AW'(idx) << 2);
   assign busy      = (state != ST_IDLE);
   assign xfer_beat = (state == ST_EXEC) && run_en && (remain != '0);
   assign xfer_addr = buf_base + (AW'(beat_ix) << 2);
   assign done_fire = (state == ST_DONE) && run_en;
   assign done_dec  = done_fire && c_dec;
   assign done_irq  = done_fire && c_irq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         idx      <= '0;
         armed    <= 1'b0;
         nxt_word <= '0;
         lnk_word <= '0;
         c_chain  <= 1'b0;
         c_irq    <= 1'b0;
         c_dec    <= 1'b0;
         c_cnt    <= '0;
         buf_base <= '0;
         remain   <= '0;
         beat_ix  <= '0;
      end else if (chan_rst) begin
         state <= ST_IDLE;
         idx   <= '0;
         armed <= 1'b0;
      end else begin
         if (arm_set) armed <= 1'b1;
         unique case (state)
            ST_IDLE: begin
               if (sw_nxt_we) nxt_word <= sw_nxt_word;
               if (armed && sem_nz && run_en) begin
                  state <= ST_FETCH;
                  idx   <= '0;
                  armed <= 1'b0;
               end
            end
            ST_FETCH: begin
               if (mem_rvalid) begin
                  case (idx)
                     2'd0: lnk_word <= mem_rdata[AW-1:2];
                     2'd1: begin
                        c_chain <= mem_rdata[CHAIN_BIT];
                        c_irq   <= mem_rdata[IRQ_BIT];
                        c_dec   <= mem_rdata[DEC_BIT];
                        c_cnt   <= mem_rdata[CNT_LSB +: CNT_W];
                     end
                     default: buf_base <= mem_rdata[AW-1:0];
                  endcase
                  if (idx == LAST_IDX) begin
                     state   <= ST_EXEC;
                     remain  <= c_cnt;
                     beat_ix <= '0;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            ST_EXEC: begin
               if (run_en) begin
                  if (remain == '0) begin
                     state <= ST_DONE;
                  end else begin
                     remain  <= remain - 1'b1;
                     beat_ix <= beat_ix + 1'b1;
                  end
               end
            end
            ST_DONE: begin
               if (run_en) begin
                  if (c_chain) nxt_word <= lnk_word;
                  if (c_chain && sem_nz_next) begin
                     state <= ST_FETCH;
                     idx   <= '0;
                     armed <= 1'b0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdma_chan.sv
module sdma_chan
   import sdma_pkg::*;
#(
   parameter int AW       = 32,
   parameter int SEM_W    = 8,
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_rst,
   input  logic              gate,
   input  logic              sw_nxt_we,
   input  logic [AW-3:0]     sw_nxt_word,
   input  logic              sem_we,
   input  logic [SEM_W-1:0]  sem_wval,
   input  logic              irq_en,
   input  logic              cmpl_clr,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              xfer_beat,
   output logic [AW-1:0]     xfer_addr,
   output logic              busy,
   output logic [AW-1:0]     nxt_addr,
   output logic [SEM_W-1:0]  sem_count,
   output logic              cmpl_flag,
   output logic              irq
);
   generate
      if (AW < 8 || AW > DATA_W) begin : g_bad_aw
         $error("sdma_chan: AW must lie in 8..32");
      end
      if (SEM_W < 1 || SEM_W > 16) begin : g_bad_sem
         $error("sdma_chan: SEM_W must lie in 1..16");
      end
      if (CNT_W < 1 || CNT_W > DATA_W - CNT_LSB) begin : g_bad_cnt
         $error("sdma_chan: CNT_W exceeds the count field");
      end
   endgenerate

   logic             run_en;
   logic             done_dec, done_irq;
   logic [SEM_W-1:0] sem_d;
   logic             arm_set;

   assign run_en  = ~gate;
   assign arm_set = sem_we && (sem_wval != '0);

   sdma_sem #(.SEM_W(SEM_W), .SATURATE(SATURATE)) u_sem (
      .clk(clk), .rst_n(rst_n), .clr(chan_rst),
      .add_we(sem_we), .add_val(sem_wval), .dec(done_dec),
      .count_q(sem_count), .count_d(sem_d)
   );

   sdma_fsm #(.AW(AW), .CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .run_en(run_en),
      .arm_set(arm_set), .sem_nz(sem_count != '0), .sem_nz_next(sem_d != '0),
      .sw_nxt_we(sw_nxt_we), .sw_nxt_word(sw_nxt_word),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .xfer_beat(xfer_beat), .xfer_addr(xfer_addr),
      .busy(busy), .nxt_addr(nxt_addr),
      .done_dec(done_dec), .done_irq(done_irq)
   );

   sdma_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(done_irq), .clr(cmpl_clr),
      .en(irq_en), .flag(cmpl_flag), .irq(irq)
   );
endmodule

// File: rtl/sdma_chk.sv
module sdma_chk #(
   parameter int AW    = 32,
   parameter int SEM_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chan_rst,
   input logic             gate,
   input logic             cmpl_clr,
   input logic             irq_en,
   input logic             mem_req,
   input logic [AW-1:0]    mem_addr,
   input logic             mem_rvalid,
   input logic             xfer_beat,
   input logic             busy,
   input logic [SEM_W-1:0] sem_count,
   input logic             cmpl_flag,
   input logic             irq
);
   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid && !chan_rst) |=> (mem_req && $stable(mem_addr)));

   // R4
   sem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(chan_rst) && sem_count < $past(sem_count)) |-> (sem_count == $past(sem_count) - 1'b1));

   // R6
   zero_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sem_count == '0) |-> !mem_req);

   // R8
   gate_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate |-> !xfer_beat);

   // R9
   irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> irq_en);

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpl_flag && !cmpl_clr) |=> cmpl_flag);

   // R10
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rst |=> (!busy && sem_count == '0));
endmodule

bind sdma_chan sdma_chk #(.AW(AW), .SEM_W(SEM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .gate(gate),
   .cmpl_clr(cmpl_clr), .irq_en(irq_en), .mem_req(mem_req),
   .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .xfer_beat(xfer_beat),
   .busy(busy), .sem_count(sem_count), .cmpl_flag(cmpl_flag), .irq(irq)
);

// File: tb/sdma_chan_tb.sv
module sdma_chan_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_rst = 1'b0, gate = 1'b0, sw_nxt_we = 1'b0;
   logic [29:0] sw_nxt_word = '0;
   logic        sem_we = 1'b0;
   logic [7:0]  sem_wval = '0;
   logic        irq_en = 1'b0, cmpl_clr = 1'b0;
   logic        mem_req, mem_rvalid = 1'b0;
   logic [31:0] mem_addr, mem_rdata = '0;
   logic        xfer_beat, busy, cmpl_flag, irq;
   logic [31:0] xfer_addr, nxt_addr;
   logic [7:0]  sem_count;

   int checks = 0, failures = 0;
   int beat_cnt = 0, mem_lat = 0, wait_cnt = 0;
   logic [31:0] mem [0:63];
   logic [31:0] exp_fetch[$];
   logic [31:0] exp_beat[$];

   always #4 clk = ~clk;

   sdma_chan u_dut (
      .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .gate(gate),
      .sw_nxt_we(sw_nxt_we), .sw_nxt_word(sw_nxt_word),
      .sem_we(sem_we), .sem_wval(sem_wval), .irq_en(irq_en), .cmpl_clr(cmpl_clr),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .xfer_beat(xfer_beat), .xfer_addr(xfer_addr),
      .busy(busy), .nxt_addr(nxt_addr), .sem_count(sem_count),
      .cmpl_flag(cmpl_flag), .irq(irq)
   );

   task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // memory model: variable latency, checks fetch order
   always @(negedge clk) begin
      if (mem_rvalid) begin
         mem_rvalid = 1'b0;
      end else if (mem_req) begin
         if (wait_cnt >= mem_lat) begin
            wait_cnt = 0;
            if (exp_fetch.size() == 0) begin
               check("R6 unexpected fetch", 1'b0, mem_addr, 32'hffff_ffff);
            end else begin
               logic [31:0] e;
               e = exp_fetch.pop_front();
               check("R2 fetch address", mem_addr == e, mem_addr, e);
            end
            mem_rdata  = mem[mem_addr[7:2]];
            mem_rvalid = 1'b1;
         end else begin
            wait_cnt++;
         end
      end else begin
         wait_cnt = 0;
      end
   end

   // beat monitor
   always @(negedge clk) begin
      if (rst_n && xfer_beat) begin
         beat_cnt++;
         if (exp_beat.size() == 0) begin
            check("R3 unexpected beat", 1'b0, xfer_addr, 32'hffff_ffff);
         end else begin
            logic [31:0] e;
            e = exp_beat.pop_front();
            check("R3 beat address", xfer_addr == e, xfer_addr, e);
         end
      end
   end

   function automatic logic [31:0] cmdw(input int cnt, input bit chain, input bit irqb, input bit dec);
      return (32'(cnt) << 16) | (32'(dec) << 6) | (32'(irqb) << 3) | (32'(chain) << 2);
   endfunction

   task automatic put_desc(input logic [31:0] a, input logic [31:0] lnk,
                           input logic [31:0] cmd, input logic [31:0] bufa);
      mem[a[7:2]]       = lnk;
      mem[a[7:2] + 6'd1] = cmd;
      mem[a[7:2] + 6'd2] = bufa;
   endtask

   task automatic expect_desc(input logic [31:0] a, input int cnt, input logic [31:0] bufa);
      exp_fetch.push_back(a);
      exp_fetch.push_back(a + 4);
      exp_fetch.push_back(a + 8);
      for (int i = 0; i < cnt; i++) exp_beat.push_back(bufa + 32'(4 * i));
   endtask

   task automatic set_nxt(input logic [31:0] a);
      @(negedge clk);
      sw_nxt_we = 1'b1; sw_nxt_word = a[31:2];
      @(negedge clk);
      sw_nxt_we = 1'b0;
   endtask

   task automatic sem_write(input logic [7:0] v);
      @(negedge clk);
      sem_we = 1'b1; sem_wval = v;
      @(negedge clk);
      sem_we = 1'b0;
   endtask

   task automatic wait_idle;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      int b0, b1;
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1 reset sem", sem_count == 0, 32'(sem_count), 0);
      check("R1 reset outputs", {busy, mem_req, cmpl_flag, irq, xfer_beat} == 5'b0,
            32'({busy, mem_req, cmpl_flag, irq, xfer_beat}), 0);

      // single descriptor, R2 R3 R4 R9
      mem_lat = 0;
      put_desc(32'h40, 32'h0, cmdw(3, 0, 1, 1), 32'h100);
      expect_desc(32'h40, 3, 32'h100);
      set_nxt(32'h40);
      sem_write(8'd1);
      wait_idle();
      check("R4 decrement to zero", sem_count == 0, 32'(sem_count), 0);
      check("R9 flag set", cmpl_flag == 1'b1, 32'(cmpl_flag), 1);
      check("R9 irq masked", irq == 1'b0, 32'(irq), 0);
      irq_en = 1'b1;
      @(negedge clk);
      check("R9 irq enabled", irq == 1'b1, 32'(irq), 1);
      cmpl_clr = 1'b1;
      @(negedge clk);
      cmpl_clr = 1'b0;
      check("R9 flag cleared", cmpl_flag == 1'b0 && irq == 1'b0, 32'(cmpl_flag), 0);

      // chain of three with zero-length middle, R5 R3
      mem_lat = 2;
      put_desc(32'h80, 32'h90, cmdw(2, 1, 0, 1), 32'h200);
      put_desc(32'h90, 32'hA0, cmdw(0, 1, 0, 1), 32'h240);
      put_desc(32'hA0, 32'h0,  cmdw(1, 0, 0, 1), 32'h280);
      expect_desc(32'h80, 2, 32'h200);
      expect_desc(32'h90, 0, 32'h240);
      expect_desc(32'hA0, 1, 32'h280);
      set_nxt(32'h80);
      sem_write(8'd3);
      wait_idle();
      check("R5 chain all fetched", exp_fetch.size() == 0, 32'(exp_fetch.size()), 0);
      check("R3 all beats seen", exp_beat.size() == 0, 32'(exp_beat.size()), 0);
      check("R5 last link pointer", nxt_addr == 32'hA0, nxt_addr, 32'hA0);
      check("R4 chain sem zero", sem_count == 0, 32'(sem_count), 0);
      check("R9 no flag without irq bit", cmpl_flag == 1'b0, 32'(cmpl_flag), 0);

      // link latched at zero, R6
      mem_lat = 1;
      put_desc(32'hC0, 32'hD0, cmdw(1, 1, 0, 1), 32'h300);
      put_desc(32'hD0, 32'h0,  cmdw(2, 0, 0, 1), 32'h310);
      expect_desc(32'hC0, 1, 32'h300);
      set_nxt(32'hC0);
      sem_write(8'd1);
      wait_idle();
      repeat (10) @(negedge clk);
      check("R6 stopped at zero", !busy && !mem_req, 32'(busy), 0);
      check("R6 link latched", nxt_addr == 32'hD0, nxt_addr, 32'hD0);
      expect_desc(32'hD0, 2, 32'h310);
      sem_write(8'd1);
      wait_idle();
      check("R6 resumed at link", exp_beat.size() == 0 && exp_fetch.size() == 0,
            32'(exp_beat.size()), 0);

      // additive and saturating semaphore while gated, R7 R8
      gate = 1'b1;
      sem_write(8'd2);
      sem_write(8'd3);
      @(negedge clk);
      check("R7 additive", sem_count == 8'd5, 32'(sem_count), 5);
      check("R8 no start gated", !busy && !mem_req, 32'(busy), 0);
      sem_write(8'd255);
      @(negedge clk);
      check("R7 saturates", sem_count == 8'd255, 32'(sem_count), 255);
      @(negedge clk);
      chan_rst = 1'b1;
      @(negedge clk);
      chan_rst = 1'b0;
      check("R10 clears sem", sem_count == 0, 32'(sem_count), 0);
      gate = 1'b0;
      sem_write(8'd0);
      repeat (5) @(negedge clk);
      check("R7 zero write inert", !busy && sem_count == 0, 32'(busy), 0);

      // gating mid-transfer, R8, and pointer write while busy, R11
      mem_lat = 3;
      put_desc(32'hE0, 32'h0, cmdw(6, 0, 0, 1), 32'h400);
      expect_desc(32'hE0, 6, 32'h400);
      set_nxt(32'hE0);
      b0 = beat_cnt;
      sem_write(8'd1);
      for (int i = 0; i < 200 && beat_cnt < b0 + 2; i++) @(negedge clk);
      gate = 1'b1;
      b1 = beat_cnt;
      set_nxt(32'h10);
      repeat (10) @(negedge clk);
      check("R8 beats frozen", beat_cnt == b1 && busy, 32'(beat_cnt), 32'(b1));
      gate = 1'b0;
      wait_idle();
      check("R8 resumed total", beat_cnt - b0 == 6, 32'(beat_cnt - b0), 6);
      check("R11 write ignored busy", nxt_addr == 32'hE0, nxt_addr, 32'hE0);

      // no decrement bit, R4
      mem_lat = 0;
      put_desc(32'h50, 32'h0, cmdw(1, 0, 0, 0), 32'h500);
      expect_desc(32'h50, 1, 32'h500);
      set_nxt(32'h50);
      sem_write(8'd1);
      wait_idle();
      check("R4 no decrement", sem_count == 8'd1, 32'(sem_count), 1);
      @(negedge clk);
      chan_rst = 1'b1;
      @(negedge clk);
      chan_rst = 1'b0;

      // abort mid-transfer, R10
      put_desc(32'hF0, 32'h0, cmdw(20, 0, 0, 1), 32'h600);
      expect_desc(32'hF0, 20, 32'h600);
      set_nxt(32'hF0);
      b0 = beat_cnt;
      sem_write(8'd1);
      for (int i = 0; i < 200 && beat_cnt < b0 + 3; i++) @(negedge clk);
      chan_rst = 1'b1;
      @(negedge clk);
      chan_rst = 1'b0;
      exp_beat.delete();
      check("R10 idle after abort", !busy && sem_count == 0, 32'(busy), 0);
      b1 = beat_cnt;
      repeat (10) @(negedge clk);
      check("R10 beats stopped", beat_cnt == b1, 32'(beat_cnt), 32'(b1));
      check("R10 pointer kept", nxt_addr == 32'hF0, nxt_addr, 32'hF0);

      // R11 idle write takes effect
      set_nxt(32'h40);
      check("R11 idle write", nxt_addr == 32'h40, nxt_addr, 32'h40);
      check("R2 no stray fetch", exp_fetch.size() == 0, 32'(exp_fetch.size()), 0);
      finish_run();
   end
endmodule